// File: doc/BRIEF.md
# Pin Function Select and Output Register Bank

This block is a memory-mapped register bank that owns the configuration and output state of a set of general-purpose pins (54 by default). Each pin carries a 3-bit function code. Ten codes are packed into each 32-bit configuration word. The code either makes the pin a plain input or a plain driven output, or hands the pin to an external alternate-function path.

Output values live in a per-pin latch. Software never rewrites that latch directly. Instead it writes a mask to a set register or to a clear register, where each 1 bit forces the matching latch high or low and each 0 bit leaves it alone. This means two agents can drive different pins without a read-modify-write race.

A level register per 32-pin bank returns the pin inputs as sampled by one register stage. Reads are combinational from the address. Writes take effect at the clock edge on which `bus_we` is high. The pin-side outputs are:
- the function code of every pin;
- the latched output value of every pin;
- an output enable per pin, derived from its function code.

Top module: `pinmux_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every function field is code 0 (input), every output latch is 0 and every output enable is 0.
- R2: Pin p owns the 3-bit field at bits (p%10)*3 of the configuration word at byte address (p/10)*4. A write stores the field and a read of that word returns it.
- R3: `pin_func[p*3 +: 3]` shows pin p's stored code from the clock edge that wrote it.
- R4: A write to the set word for bank b (byte address 0x1C + 4*b) sets the latch of pin 32*b+i for every 1 in data bit i. Zero bits leave latches unchanged. `pin_out` shows the latch.
- R5: A write to the clear word for bank b (byte address 0x28 + 4*b) clears the latch of pin 32*b+i for every 1 in data bit i. Zero bits leave latches unchanged.
- R6: The set and clear words always read as zero.
- R7: The level word for bank b (byte address 0x34 + 4*b) returns `pin_in` as sampled at the most recent clock edge. A change on `pin_in` shows up in a read only after the next edge.
- R8: `pin_oe[p]` is 1 only while pin p's code is 1 (output). Code 0 (input) and codes 2 to 7 (alternate functions) keep it 0.
- R9: Bits with no pin behind them read as zero and ignore writes. These are bits 30 and 31 of every configuration word, the fields past the last pin in the last word, and bank 1 bits 22 to 31 of the set, clear and level words.
- R10: The output latch is kept whatever the pin's function. A value set while the pin is an input appears with output enable once the code becomes 1.
- R11: Addresses outside the mapped words, and addresses not aligned to 4 bytes, read as zero. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Byte address of the accessed word |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 54 | Pin input levels |
| pin_func | output | 162 | Function code per pin, 3 bits each, pin 0 in the low bits |
| pin_out | output | 54 | Output latch per pin |
| pin_oe | output | 54 | Output enable per pin |

## Verification
A pin may change its input level in the same cycle in which software reads that bank's level word. The bench drives a new pattern on `pin_in` and reads the level words before the next clock edge. It expects the old sampled value, then reads again after the edge and expects the new value in both banks.

The other coincidence is an output-latch update on a pin whose function is not output. The bench sets a latch while the pin is an input. It checks that the value is already on `pin_out` with the enable low, and that the enable rises without disturbing the value once the code switches to output.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int DATA_W      = 32;
  localparam int FN_W        = 3;
  localparam int FN_PER_WORD = 10;
  localparam int BANK_W      = 32;
  localparam int IDX_W       = 4;
  // word indexes (byte address / 4) of the first word of each region
  localparam int SET_WORD    = 7;
  localparam int CLR_WORD    = 10;
  localparam int LEV_WORD    = 13;

  typedef logic [FN_W-1:0] fn_code_t;
  localparam fn_code_t FN_INPUT  = 3'd0;
  localparam fn_code_t FN_OUTPUT = 3'd1;

  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_FSEL = 3'd1,
    RG_SET  = 3'd2,
    RG_CLR  = 3'd3,
    RG_LEV  = 3'd4
  } region_t;
endpackage

// File: rtl/pinmux_addr_decode.sv
module pinmux_addr_decode
  import pinmux_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_FWORDS = 6,
  parameter int NUM_BANKS  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output region_t           region,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    int w;
    w      = int'(addr[ADDR_W-1:2]);
    region = RG_NONE;
    idx    = '0;
    if (addr[1:0] == 2'b00) begin
      if (w < NUM_FWORDS) begin
        region = RG_FSEL;
        idx    = IDX_W'(w);
      end else if (w >= SET_WORD && w < SET_WORD + NUM_BANKS) begin
        region = RG_SET;
        idx    = IDX_W'(w - SET_WORD);
      end else if (w >= CLR_WORD && w < CLR_WORD + NUM_BANKS) begin
        region = RG_CLR;
        idx    = IDX_W'(w - CLR_WORD);
      end else if (w >= LEV_WORD && w < LEV_WORD + NUM_BANKS) begin
        region = RG_LEV;
        idx    = IDX_W'(w - LEV_WORD);
      end
    end
  end
endmodule

// File: rtl/pinmux_fsel_regs.sv
module pinmux_fsel_regs
  import pinmux_pkg::*;
#(
  parameter int NUM_PINS   = 54,
  parameter int NUM_FWORDS = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [FN_PER_WORD*FN_W-1:0]   wr_field,
  output logic [NUM_PINS*FN_W-1:0]      fn_flat,
  output logic [NUM_FWORDS*DATA_W-1:0]  rd_words
);
  fn_code_t fn_q [NUM_PINS];
  fn_code_t fn_d [NUM_PINS];

  // next state: only the pins of the addressed word take new fields
  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      fn_d[p] = fn_q[p];
      if (wr_idx == IDX_W'(p / FN_PER_WORD))
        fn_d[p] = wr_field[(p % FN_PER_WORD)*FN_W +: FN_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PINS; p++) fn_q[p] <= FN_INPUT;
    end else if (wr_en) begin
      for (int p = 0; p < NUM_PINS; p++) fn_q[p] <= fn_d[p];
    end
  end

  // flat code vector and packed read words; unbacked bits stay zero
  always_comb begin
    fn_flat  = '0;
    rd_words = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      fn_flat[p*FN_W +: FN_W] = fn_q[p];
      rd_words[(p / FN_PER_WORD)*DATA_W + (p % FN_PER_WORD)*FN_W +: FN_W] = fn_q[p];
    end
  end
endmodule

// File: rtl/pinmux_out_latch.sv
module pinmux_out_latch
  import pinmux_pkg::*;
#(
  parameter int NUM_PINS = 54
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic                clr_en,
  input  logic [IDX_W-1:0]    bank_idx,
  input  logic [DATA_W-1:0]   wdata,
  output logic [NUM_PINS-1:0] latch_q
);
  logic [NUM_PINS-1:0] latch_d;
  logic                upd_en;

  assign upd_en = set_en | clr_en;

  always_comb begin
    latch_d = latch_q;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (bank_idx == IDX_W'(p / BANK_W) && wdata[p % BANK_W]) begin
        if (set_en)      latch_d[p] = 1'b1;
        else if (clr_en) latch_d[p] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      latch_q <= '0;
    else if (upd_en) latch_q <= latch_d;
  end
endmodule

// File: rtl/pinmux_level_sample.sv
module pinmux_level_sample #(
  parameter int NUM_PINS = 54
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] lvl_q
);
  logic [NUM_PINS-1:0] lvl_d;
  logic                smp_en;

  assign smp_en = 1'b1;
  assign lvl_d  = pin_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (smp_en) lvl_q <= lvl_d;
  end
endmodule

// File: rtl/pinmux_bank.sv
module pinmux_bank
  import pinmux_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_we,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [NUM_PINS-1:0]      pin_in,
  output logic [NUM_PINS*FN_W-1:0] pin_func,
  output logic [NUM_PINS-1:0]      pin_out,
  output logic [NUM_PINS-1:0]      pin_oe
);
  localparam int NUM_FWORDS = (NUM_PINS + FN_PER_WORD - 1) / FN_PER_WORD;
  localparam int NUM_BANKS  = (NUM_PINS + BANK_W - 1) / BANK_W;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  region_t           region;
  logic [IDX_W-1:0]  idx;

  pinmux_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_FWORDS(NUM_FWORDS), .NUM_BANKS(NUM_BANKS)
  ) u_dec (
    .addr(bus_addr), .region(region), .idx(idx)
  );

  logic fsel_we, set_we, clr_we;
  assign fsel_we = bus_we && (region == RG_FSEL);
  assign set_we  = bus_we && (region == RG_SET);
  assign clr_we  = bus_we && (region == RG_CLR);

  logic [NUM_FWORDS*DATA_W-1:0] fsel_words;

  pinmux_fsel_regs #(
    .NUM_PINS(NUM_PINS), .NUM_FWORDS(NUM_FWORDS)
  ) u_fsel (
    .clk(clk), .rst_n(rst_int_n), .wr_en(fsel_we), .wr_idx(idx),
    .wr_field(bus_wdata[FN_PER_WORD*FN_W-1:0]),
    .fn_flat(pin_func), .rd_words(fsel_words)
  );

  pinmux_out_latch #(
    .NUM_PINS(NUM_PINS)
  ) u_latch (
    .clk(clk), .rst_n(rst_int_n), .set_en(set_we), .clr_en(clr_we),
    .bank_idx(idx), .wdata(bus_wdata), .latch_q(pin_out)
  );

  logic [NUM_PINS-1:0] lvl_q;

  pinmux_level_sample #(
    .NUM_PINS(NUM_PINS)
  ) u_lvl (
    .clk(clk), .rst_n(rst_int_n), .pin_in(pin_in), .lvl_q(lvl_q)
  );

  // output enable follows the function code of each pin
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
    assign pin_oe[p] = (pin_func[p*FN_W +: FN_W] == FN_OUTPUT);
  end

  logic [NUM_BANKS*BANK_W-1:0] lvl_pad;
  always_comb begin
    lvl_pad                 = '0;
    lvl_pad[NUM_PINS-1:0]   = lvl_q;
  end

  always_comb begin
    case (region)
      RG_FSEL: bus_rdata = fsel_words[int'(idx)*DATA_W +: DATA_W];
      RG_LEV:  bus_rdata = lvl_pad[int'(idx)*BANK_W +: DATA_W];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pinmux_bank_chk.sv
module pinmux_bank_chk
  import pinmux_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic                     bus_we,
  input logic [DATA_W-1:0]        bus_wdata,
  input logic [DATA_W-1:0]        bus_rdata,
  input logic [NUM_PINS*FN_W-1:0] pin_func,
  input logic [NUM_PINS-1:0]      pin_out,
  input logic [NUM_PINS-1:0]      pin_oe
);
  localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(SET_WORD*4);
  localparam logic [ADDR_W-1:0] A_SET1 = ADDR_W'(SET_WORD*4 + 4);
  localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(CLR_WORD*4);
  localparam logic [ADDR_W-1:0] A_CLR1 = ADDR_W'(CLR_WORD*4 + 4);
  localparam logic [ADDR_W-1:0] A_LEV1 = ADDR_W'(LEV_WORD*4 + 4);

  logic at_latch_word;
  assign at_latch_word = (bus_addr == A_SET0) || (bus_addr == A_SET1) ||
                         (bus_addr == A_CLR0) || (bus_addr == A_CLR1);

  // R1: reset holds every pin output quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (pin_out == '0 && pin_oe == '0 && pin_func == '0));

  // R4: ones written to set word 0 appear on the latches
  p_set_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SET0) |=>
      ((pin_out[DATA_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

  // R5: ones written to clear word 0 drop the latches
  p_clr_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CLR0) |=>
      ((pin_out[DATA_W-1:0] & $past(bus_wdata)) == '0));

  // R4: latches move only through the set/clear words
  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && at_latch_word) |=> $stable(pin_out));

  // R8: function codes and enables change only on a write
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(pin_oe) && $stable(pin_func)));

  // R6: set/clear words read as zero
  p_latch_rd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    at_latch_word |-> (bus_rdata == '0));

  // R9: unbacked bits of the bank 1 level word read zero
  p_lvl1_pad_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_LEV1) |-> (bus_rdata[DATA_W-1:NUM_PINS-BANK_W] == '0));
endmodule

bind pinmux_bank pinmux_bank_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_int_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_func(pin_func),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/sim_pinmux_bank.sv
module sim_pinmux_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 54;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [7:0]     bus_addr;
  logic           bus_we;
  logic [31:0]    bus_wdata;
  logic [31:0]    bus_rdata;
  logic [NP-1:0]  pin_in;
  logic [NP*3-1:0] pin_func;
  logic [NP-1:0]  pin_out;
  logic [NP-1:0]  pin_oe;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinmux_bank #(.NUM_PINS(NP), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_func(pin_func), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [31:0] data;   // write data, or expected read data
  } vec_t;

  // R2 R6 R9 R11 register-level vectors
  localparam vec_t VECS [16] = '{
    '{1'b1, 8'h00, 32'hFFFF_FFFF},
    '{1'b0, 8'h00, 32'h3FFF_FFFF},
    '{1'b1, 8'h14, 32'hFFFF_FFFF},
    '{1'b0, 8'h14, 32'h0000_0FFF},
    '{1'b1, 8'h04, 32'h1234_5678},
    '{1'b0, 8'h04, 32'h1234_5678},
    '{1'b1, 8'h0C, 32'hC000_0001},
    '{1'b0, 8'h0C, 32'h0000_0001},
    '{1'b0, 8'h1C, 32'h0000_0000},
    '{1'b0, 8'h2C, 32'h0000_0000},
    '{1'b1, 8'h18, 32'h0000_FFFF},
    '{1'b0, 8'h18, 32'h0000_0000},
    '{1'b1, 8'h02, 32'hFFFF_FFFF},
    '{1'b0, 8'h00, 32'h3FFF_FFFF},
    '{1'b1, 8'h3C, 32'hFFFF_FFFF},
    '{1'b0, 8'h3C, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, {32'd0, bus_rdata}, {32'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 out in reset", {10'd0, pin_out}, 64'd0);
    check("R1 oe in reset",  {10'd0, pin_oe}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 func after reset", {32'd0, pin_func[31:0]}, 64'd0);
    rd_check("R1 word0 after reset", 8'h00, 32'h0);
    rd_check("R1 word5 after reset", 8'h14, 32'h0);

    // table walk
    for (int i = 0; i < 16; i++) begin
      if (VECS[i].we) wr(VECS[i].addr, VECS[i].data);
      else rd_check($sformatf("R2 R6 R9 R11 vector %0d", i), VECS[i].addr, VECS[i].data);
    end
    // alternate codes (7) on pins 0..9: enable stays low
    check("R8 alt code no oe", {54'd0, pin_oe[9:0]}, 64'd0);
    check("R3 func pin 4 code", {61'd0, pin_func[4*3 +: 3]}, 64'd7);
    check("R11 no latch from bad writes", {10'd0, pin_out}, 64'd0);
    for (int w = 0; w < 6; w++) wr(8'(w*4), 32'h0);

    // R3 R8: pin 13 to output
    wr(8'h04, 32'h1 << 9);
    check("R3 pin13 func", {61'd0, pin_func[13*3 +: 3]}, 64'd1);
    check("R8 only pin13 oe", {10'd0, pin_oe}, 64'd1 << 13);
    for (int c = 0; c < 8; c++) begin
      wr(8'h00, 32'(c));
      check($sformatf("R8 pin0 code %0d", c), {63'd0, pin_oe[0]}, {63'd0, c == 1});
    end
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0);

    // R4 R5
    wr(8'h1C, 32'h0000_0005);
    check("R4 set bits", {10'd0, pin_out}, 64'h5);
    wr(8'h1C, 32'h0);
    check("R4 zero set no effect", {10'd0, pin_out}, 64'h5);
    rd_check("R6 set reads zero", 8'h1C, 32'h0);
    rd_check("R6 clear reads zero", 8'h28, 32'h0);
    wr(8'h28, 32'h0000_0001);
    check("R5 clear bit", {10'd0, pin_out}, 64'h4);
    wr(8'h28, 32'h0);
    check("R5 zero clear no effect", {10'd0, pin_out}, 64'h4);

    // R9: bank 1 upper bits ignored
    wr(8'h20, 32'hFFFF_FFFF);
    check("R9 bank1 set", {10'd0, pin_out}, {10'd0, 22'h3F_FFFF, 32'h4});
    wr(8'h2C, 32'hFFFF_FFFF);
    check("R9 bank1 clear", {10'd0, pin_out}, 64'h4);
    wr(8'h28, 32'h4);

    // R10: latch set while input, then switch to output
    wr(8'h20, 32'h1 << 8);
    check("R10 latch while input", {62'd0, pin_out[40], pin_oe[40]}, 64'b10);
    wr(8'h10, 32'h1);
    check("R10 latch kept on output", {62'd0, pin_out[40], pin_oe[40]}, 64'b11);

    // R7: level change in the same cycle as a read
    @(negedge clk);
    pin_in = 54'h2A_5A5A_1234_5678;
    rd_check("R7 same-cycle old bank0", 8'h34, 32'h0);
    @(negedge clk);
    rd_check("R7 sampled bank0", 8'h34, 32'h1234_5678);
    rd_check("R7 R9 sampled bank1", 8'h38, 32'h002A_5A5A);
    pin_in = '1;
    @(negedge clk);
    rd_check("R7 R9 all-ones bank1", 8'h38, 32'h003F_FFFF);

    // R1: reset in mid-run
    #1 rst_n = 1'b0;
    #1;
    check("R1 async out clear", {10'd0, pin_out}, 64'd0);
    check("R1 async oe clear", {10'd0, pin_oe}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_check("R1 word4 after reset", 8'h10, 32'h0);

    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule